// File: doc/BRIEF.md
# Five-Stage Load/Store Pipeline Core

This block is a small in-order pipelined core for a toy 16-bit load/store instruction set. It holds its own program counter, eight general registers, a 256-word instruction store and a 256-word data store. Work moves through five stages: fetch, operand fetch, execute, memory access and write-back. Each instruction class does real work only in the stages it needs. Register-to-register and immediate adds compute in execute and retire in write-back. They pass through the memory slot without touching the data store. Loads read the data store in the memory slot and write the register file in write-back. Stores write the data store in the memory slot and never reach write-back. Branches resolve and retire in execute.

Operands come from the register file or are forwarded from later stages. A load that feeds the next instruction costs one bubble. A conditional branch is predicted not taken. When it is taken, the two younger instructions are squashed and fetch restarts at the target.

While the core is held in reset, a test harness fills both memories through a load port. Debug outputs give combinational views of any register, any data word and the program counter.

Top module: `pipe_core`

## Requirements
- R1: While rstN is low the program counter reads 0, all eight registers read 0 and no instruction is in flight. Load port writes go to the instruction store when progSel=0 and to the data store when progSel=1, and only while rstN is low. While the core runs they are ignored. dbgRegData and dbgMemData show the selected register and data word combinationally.
- R2: Instruction word layout: bits [15:12] opcode (0 no-op, 1 ADD, 2 ADDI, 3 LD, 4 ST, 5 BEQ); bits [11:9] destination, store-data or first compare register; bits [8:6] source or base register; bits [5:3] second ADD source; bits [5:0] signed 6-bit immediate. ADD writes rd = ra + rb modulo 2^16.
- R3: ADDI writes rd = ra + sign-extended immediate, modulo 2^16.
- R4: LD writes rd with the data word at address (ra + sign-extended immediate) modulo 256.
- R5: ST writes register [11:9] to the data word at (ra + sign-extended immediate) modulo 256 and changes no register.
- R6: ADD and ADDI never write the data store.
- R7: BEQ compares register [11:9] with register [8:6]. If they are equal, fetch continues at the branch's own address plus the sign-extended immediate, and the two instructions after the branch have no effect. Otherwise execution falls through. BEQ writes no register and no memory.
- R8: After reset is released, the instruction at address i with no stall ahead of it updates its register at rising edge i+5. An instruction that directly follows a load and reads the loaded register is delayed by exactly one cycle. Dependent adds in back-to-back order are not delayed.
- R9: The sequence LD r1,off(r2); ADDI r1,r1,1; ST r1,off(r2) leaves that data word increased by exactly one, modulo 2^16, and leaves every other word unchanged.
- R10: A source register written 1, 2 or 3 instructions earlier is read with its new value. This includes a read made in the same cycle as the write-back to that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset; memory load window |
| progWe | input | 1 | Load port write strobe (effective only in reset) |
| progSel | input | 1 | Load target: 0 instruction store, 1 data store |
| progAddr | input | 8 | Load port word address |
| progData | input | 16 | Load port write data |
| dbgRegSel | input | 3 | Register selected for debug view |
| dbgRegData | output | 16 | Content of the selected register |
| dbgMemAddr | input | 8 | Data word selected for debug view |
| dbgMemData | output | 16 | Content of the selected data word |
| dbgPc | output | 8 | Current fetch address |

## Verification
Register results appear on the debug port five rising edges after their instruction's fetch edge, and each load-use pairing adds one edge. The timing checks therefore count edges from reset release and sample the register after every falling edge, which catches both early and late results. All functional checks run each program for thirty edges, well past the last write-back and well before the fetch address could wrap. They then sample the debug views while the core only streams no-ops. Data-store results are due one edge after the store's memory slot, and the same settled window covers them.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int REG_AW  = 3;
  localparam int NREGS   = 1 << REG_AW;
  localparam int IMM_W   = 6;

  localparam logic [OPC_W-1:0] OP_ADD  = 4'd1;
  localparam logic [OPC_W-1:0] OP_ADDI = 4'd2;
  localparam logic [OPC_W-1:0] OP_LD   = 4'd3;
  localparam logic [OPC_W-1:0] OP_ST   = 4'd4;
  localparam logic [OPC_W-1:0] OP_BEQ  = 4'd5;

  typedef enum logic [1:0] {FW_RF, FW_EX, FW_MA} fwd_e;

  typedef struct packed {
    logic              regWrite;
    logic              memRead;
    logic              memWrite;
    logic              useImm;
    logic              branch;
    logic [REG_AW-1:0] dst;
  } decode_t;

  // strobes from control to datapath
  typedef struct packed {
    decode_t           dec;
    logic [REG_AW-1:0] srcA;
    logic [REG_AW-1:0] srcB;
    fwd_e              fwdA;
    fwd_e              fwdB;
    logic              stall;
    logic              flush;
  } ctrl_t;

  // pipeline occupancy seen by control and checker
  typedef struct packed {
    logic    exValid;
    decode_t exDec;
    logic    maValid;
    decode_t maDec;
    logic    wbValid;
    logic    wbLoad;
  } pipeView_t;

  function automatic decode_t decodeInstr(input logic [INSTR_W-1:0] ins);
    decode_t d;
    d = '0;
    d.dst = ins[11:9];
    case (ins[15:12])
      OP_ADD:  d.regWrite = 1'b1;
      OP_ADDI: begin d.regWrite = 1'b1; d.useImm = 1'b1; end
      OP_LD:   begin d.regWrite = 1'b1; d.memRead = 1'b1; d.useImm = 1'b1; end
      OP_ST:   begin d.memWrite = 1'b1; d.useImm = 1'b1; end
      OP_BEQ:  d.branch = 1'b1;
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/core_ctrl.sv
module core_ctrl
  import core_pkg::*;
(
  input  logic               ofValid,
  input  logic [INSTR_W-1:0] ofInstr,
  input  pipeView_t          view,
  input  logic               brTaken,
  output ctrl_t              strobes
);
  logic [OPC_W-1:0] op;
  logic useA, useB;

  function automatic fwd_e pickFwd(input logic [REG_AW-1:0] r, input pipeView_t v);
    if (v.exValid && v.exDec.regWrite && !v.exDec.memRead && v.exDec.dst == r) return FW_EX;
    if (v.maValid && v.maDec.regWrite && v.maDec.dst == r) return FW_MA;
    return FW_RF;
  endfunction

  assign op = ofInstr[15:12];

  always_comb begin
    strobes      = '0;
    strobes.dec  = ofValid ? decodeInstr(ofInstr) : '0;
    strobes.srcA = ofInstr[8:6];
    strobes.srcB = (op == OP_ADD) ? ofInstr[5:3] : ofInstr[11:9];
    useA = ofValid && (op inside {OP_ADD, OP_ADDI, OP_LD, OP_ST, OP_BEQ});
    useB = ofValid && (op inside {OP_ADD, OP_ST, OP_BEQ});
    strobes.fwdA = pickFwd(strobes.srcA, view);
    strobes.fwdB = pickFwd(strobes.srcB, view);
    // load in execute feeding the instruction in operand fetch
    strobes.stall = view.exValid && view.exDec.memRead &&
                    ((useA && view.exDec.dst == strobes.srcA) ||
                     (useB && view.exDec.dst == strobes.srcB));
    strobes.flush = brTaken;
  end
endmodule

// File: rtl/core_datapath.sv
module core_datapath
  import core_pkg::*;
#(
  parameter  int DATA_W    = 16,
  parameter  int MEM_DEPTH = 256,
  localparam int ADDR_W    = $clog2(MEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               progWe,
  input  logic               progSel,
  input  logic [ADDR_W-1:0]  progAddr,
  input  logic [DATA_W-1:0]  progData,
  input  logic [REG_AW-1:0]  dbgRegSel,
  output logic [DATA_W-1:0]  dbgRegData,
  input  logic [ADDR_W-1:0]  dbgMemAddr,
  output logic [DATA_W-1:0]  dbgMemData,
  output logic [ADDR_W-1:0]  dbgPc,
  input  ctrl_t              strobes,
  output logic               ofValid,
  output logic [INSTR_W-1:0] ofInstr,
  output pipeView_t          view,
  output logic               brTaken,
  output logic [ADDR_W-1:0]  brTarget,
  output logic               memWe,
  output logic               memRe,
  output logic               rfWe
);
  logic [INSTR_W-1:0] imem [MEM_DEPTH];
  logic [DATA_W-1:0]  dmem [MEM_DEPTH];
  logic [DATA_W-1:0]  regs [NREGS];

  logic [ADDR_W-1:0] pc, ofPc, exPc, rdAddr, wrAddr;
  logic [DATA_W-1:0] exA, exB, exImm, aluB, aluSum;
  logic [DATA_W-1:0] maAlu, maStore, memRd, maResult, wbData;
  decode_t           exDec, maDec;
  logic              exValid, maValid, wbValid, wbLoad;
  logic [REG_AW-1:0] wbDst;

  logic [REG_AW-1:0] srcIdx [2];
  fwd_e              fwdSel [2];
  logic [DATA_W-1:0] opVal  [2];

  assign srcIdx[0] = strobes.srcA;
  assign srcIdx[1] = strobes.srcB;
  assign fwdSel[0] = strobes.fwdA;
  assign fwdSel[1] = strobes.fwdB;

  // operand fetch: forward from execute / memory slot, else register file with write-back bypass
  for (genvar k = 0; k < 2; k++) begin : g_opnd
    assign opVal[k] = (fwdSel[k] == FW_EX) ? aluSum :
                      (fwdSel[k] == FW_MA) ? maResult :
                      (rfWe && wbDst == srcIdx[k]) ? wbData : regs[srcIdx[k]];
  end

  // instruction store, loadable only in reset
  always_ff @(posedge clk)
    if (!rstN && progWe && !progSel) imem[progAddr] <= progData[INSTR_W-1:0];

  // fetch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= '0; ofPc <= '0; ofInstr <= '0; ofValid <= 1'b0;
    end else if (strobes.flush) begin
      pc <= brTarget; ofValid <= 1'b0;
    end else if (!strobes.stall) begin
      pc <= pc + 1'b1; ofPc <= pc; ofInstr <= imem[pc]; ofValid <= 1'b1;
    end
  end

  // execute stage registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      exValid <= 1'b0; exDec <= '0; exPc <= '0; exA <= '0; exB <= '0; exImm <= '0;
    end else begin
      exValid <= ofValid && !strobes.stall && !strobes.flush;
      exDec   <= strobes.dec;
      exPc    <= ofPc;
      exA     <= opVal[0];
      exB     <= opVal[1];
      exImm   <= {{(DATA_W-IMM_W){ofInstr[IMM_W-1]}}, ofInstr[IMM_W-1:0]};
    end
  end

  assign aluB     = exDec.useImm ? exImm : exB;
  assign aluSum   = exA + aluB;
  assign brTaken  = exValid && exDec.branch && (exA == exB);
  assign brTarget = exPc + exImm[ADDR_W-1:0];
  assign memRe    = exValid && exDec.memRead;
  assign rdAddr   = aluSum[ADDR_W-1:0];

  // memory slot: branches retire here by not advancing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maValid <= 1'b0; maDec <= '0; maAlu <= '0; maStore <= '0;
    end else begin
      maValid <= exValid && !exDec.branch;
      maDec   <= exDec;
      maAlu   <= aluSum;
      maStore <= exB;
    end
  end

  assign memWe  = maValid && maDec.memWrite;
  assign wrAddr = maAlu[ADDR_W-1:0];

  // data store: write in memory slot, read issued from execute (write-first)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      if (progWe && progSel) dmem[progAddr] <= progData;
    end else if (memWe) begin
      dmem[wrAddr] <= maStore;
    end
  end

  always_ff @(posedge clk)
    memRd <= (memWe && wrAddr == rdAddr) ? maStore : dmem[rdAddr];

  assign maResult = maDec.memRead ? memRd : maAlu;

  // write-back: stores do not advance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValid <= 1'b0; wbDst <= '0; wbData <= '0; wbLoad <= 1'b0;
    end else begin
      wbValid <= maValid && maDec.regWrite;
      wbDst   <= maDec.dst;
      wbData  <= maResult;
      wbLoad  <= maDec.memRead;
    end
  end

  assign rfWe = wbValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (rfWe) begin
      regs[wbDst] <= wbData;
    end
  end

  assign view       = '{exValid: exValid, exDec: exDec, maValid: maValid, maDec: maDec,
                        wbValid: wbValid, wbLoad: wbLoad};
  assign dbgRegData = regs[dbgRegSel];
  assign dbgMemData = dmem[dbgMemAddr];
  assign dbgPc      = pc;
endmodule

// File: rtl/pipe_core.sv
module pipe_core
  import core_pkg::*;
#(
  parameter  int DATA_W    = 16,
  parameter  int MEM_DEPTH = 256,
  localparam int ADDR_W    = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progWe,
  input  logic              progSel,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [DATA_W-1:0] progData,
  input  logic [REG_AW-1:0] dbgRegSel,
  output logic [DATA_W-1:0] dbgRegData,
  input  logic [ADDR_W-1:0] dbgMemAddr,
  output logic [DATA_W-1:0] dbgMemData,
  output logic [ADDR_W-1:0] dbgPc
);
  ctrl_t              strobes;
  pipeView_t          view;
  logic               ofValid, brTaken, memWe, memRe, rfWe;
  logic [INSTR_W-1:0] ofInstr;
  logic [ADDR_W-1:0]  brTarget;

  core_ctrl uCtrl (
    .ofValid(ofValid), .ofInstr(ofInstr), .view(view), .brTaken(brTaken), .strobes(strobes)
  );

  core_datapath #(.DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH)) uDp (
    .clk(clk), .rstN(rstN),
    .progWe(progWe), .progSel(progSel), .progAddr(progAddr), .progData(progData),
    .dbgRegSel(dbgRegSel), .dbgRegData(dbgRegData),
    .dbgMemAddr(dbgMemAddr), .dbgMemData(dbgMemData), .dbgPc(dbgPc),
    .strobes(strobes), .ofValid(ofValid), .ofInstr(ofInstr), .view(view),
    .brTaken(brTaken), .brTarget(brTarget), .memWe(memWe), .memRe(memRe), .rfWe(rfWe)
  );
endmodule

// File: rtl/core_checker.sv
module core_checker
  import core_pkg::*;
#(parameter int ADDR_W = 8) (
  input logic              clk,
  input logic              rstN,
  input ctrl_t             strobes,
  input pipeView_t         view,
  input logic              ofValid,
  input logic              brTaken,
  input logic [ADDR_W-1:0] brTarget,
  input logic [ADDR_W-1:0] dbgPc,
  input logic              memWe,
  input logic              memRe,
  input logic              rfWe
);
  // R5: a store in the memory slot never produces a register write
  a_r5_store_no_writeback: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !rfWe);

  // R4: a load's register write follows its data-store read two cycles earlier
  a_r4_load_reads_store: assert property (@(posedge clk) disable iff (!rstN)
    (rfWe && view.wbLoad) |-> $past(memRe, 2));

  // R6: an add in execute never writes the data store in the next cycle
  a_r6_add_no_store_write: assert property (@(posedge clk) disable iff (!rstN)
    (view.exValid && view.exDec.regWrite && !view.exDec.memRead) |=> !memWe);

  // R7: branches retire after execute
  a_r7_branch_retires: assert property (@(posedge clk) disable iff (!rstN)
    (view.exValid && view.exDec.branch) |=> !view.maValid);

  // R7: taken branch redirects fetch and squashes the younger pair
  a_r7_redirect_flush: assert property (@(posedge clk) disable iff (!rstN)
    brTaken |=> (dbgPc == $past(brTarget) && !ofValid && !view.exValid));

  // R8: a load-use stall holds fetch and inserts one bubble
  a_r8_stall_bubble: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stall |=> ($stable(dbgPc) && !view.exValid));
endmodule

bind pipe_core core_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .strobes(strobes), .view(view), .ofValid(ofValid),
  .brTaken(brTaken), .brTarget(brTarget), .dbgPc(dbgPc),
  .memWe(memWe), .memRe(memRe), .rfWe(rfWe)
);

// File: tb/pipe_core_test.sv
`timescale 1ns/1ps
module pipe_core_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        progWe = 1'b0, progSel = 1'b0;
  logic [7:0]  progAddr = '0;
  logic [15:0] progData = '0;
  logic [2:0]  dbgRegSel = '0;
  logic [15:0] dbgRegData;
  logic [7:0]  dbgMemAddr = '0;
  logic [15:0] dbgMemData;
  logic [7:0]  dbgPc;

  int checks = 0, errors = 0;
  logic [15:0] prog   [16];
  logic [15:0] dmInit [256];
  logic [15:0] vals   [8] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
                              16'h8000, 16'hFFFF, 16'h1234, 16'hAAAA};

  always #5 clk = ~clk;

  pipe_core uut (
    .clk(clk), .rstN(rstN), .progWe(progWe), .progSel(progSel), .progAddr(progAddr),
    .progData(progData), .dbgRegSel(dbgRegSel), .dbgRegData(dbgRegData),
    .dbgMemAddr(dbgMemAddr), .dbgMemData(dbgMemData), .dbgPc(dbgPc)
  );

  // encoders, per R2 layout
  function automatic logic [15:0] iADD(int rd, int ra, int rb);
    return {4'd1, 3'(rd), 3'(ra), 3'(rb), 3'b000};
  endfunction
  function automatic logic [15:0] iADDI(int rd, int ra, int imm);
    return {4'd2, 3'(rd), 3'(ra), 6'(imm)};
  endfunction
  function automatic logic [15:0] iLD(int rd, int ra, int imm);
    return {4'd3, 3'(rd), 3'(ra), 6'(imm)};
  endfunction
  function automatic logic [15:0] iST(int rs, int ra, int imm);
    return {4'd4, 3'(rs), 3'(ra), 6'(imm)};
  endfunction
  function automatic logic [15:0] iBEQ(int rx, int ry, int off);
    return {4'd5, 3'(rx), 3'(ry), 6'(off)};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rdReg(input int r, output logic [15:0] v);
    dbgRegSel = 3'(r); #1; v = dbgRegData;
  endtask

  task automatic rdMem(input int a, output logic [15:0] v);
    dbgMemAddr = 8'(a); #1; v = dbgMemData;
  endtask

  task automatic clearProg();
    for (int i = 0; i < 16; i++) prog[i] = 16'h0000;
    for (int i = 0; i < 256; i++) dmInit[i] = 16'(i * 37 + 5);
  endtask

  // hold reset, fill both stores, release and run n edges
  task automatic runProg(input int n);
    @(negedge clk); rstN = 1'b0;
    progWe = 1'b1; progSel = 1'b0;
    for (int i = 0; i < 16; i++) begin
      progAddr = 8'(i); progData = prog[i]; @(negedge clk);
    end
    progSel = 1'b1;
    for (int i = 0; i < 256; i++) begin
      progAddr = 8'(i); progData = dmInit[i]; @(negedge clk);
    end
    progWe = 1'b0;
    rstN = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // count data words differing from the initial image, skipping one address
  task automatic memDiff(input int skip, output int n);
    logic [15:0] v;
    n = 0;
    for (int i = 0; i < 256; i++) begin
      rdMem(i, v);
      if (i != skip && v !== dmInit[i]) n++;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] v, exp;
    int n, first;

    // clear the whole instruction store to no-ops during reset
    repeat (2) @(negedge clk);
    progWe = 1'b1; progSel = 1'b0; progData = '0;
    for (int i = 0; i < 256; i++) begin progAddr = 8'(i); @(negedge clk); end
    progWe = 1'b0;
    check("R1 reset pc", {8'h00, dbgPc}, 16'h0000);
    n = 0;
    for (int r = 0; r < 8; r++) begin rdReg(r, v); if (v !== 16'h0) n++; end
    check("R1 reset regs", 16'(n), 16'h0000);

    // R2/R4/R5/R6: load two words, add, store; sweep operand pairs
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        clearProg();
        dmInit[0] = vals[a]; dmInit[1] = vals[b];
        prog[0] = iLD(1, 0, 0); prog[1] = iLD(2, 0, 1);
        prog[2] = iADD(3, 1, 2); prog[3] = iST(3, 0, 2);
        runProg(30);
        exp = vals[a] + vals[b];
        rdReg(3, v); check("R2 add sum", v, exp);
        rdReg(1, v); check("R4 load value", v, vals[a]);
        rdMem(2, v); check("R5 stored word", v, exp);
        memDiff(2, n); check("R6 other words untouched", 16'(n), 16'h0000);
        n = 0;
        for (int r = 4; r < 8; r++) begin rdReg(r, v); if (v !== 16'h0) n++; end
        check("R5 store writes no register", 16'(n), 16'h0000);
      end
    end

    // R3/R10: immediate sweep with back-to-back and distance-2 dependencies
    for (int imm = -32; imm < 32; imm++) begin
      clearProg();
      prog[0] = iADDI(1, 0, imm); prog[1] = iADDI(2, 1, imm); prog[2] = iADD(3, 2, 1);
      runProg(30);
      rdReg(1, v); check("R3 sign-extended immediate", v, 16'(imm));
      rdReg(2, v); check("R3 immediate chain", v, 16'(2 * imm));
      rdReg(3, v); check("R10 forward from execute and memory slot", v, 16'(3 * imm));
    end

    // R9/R4: increment sequence over bases and offsets, with address wrap
    begin
      int bases [5] = '{-32, -1, 0, 5, 31};
      int offs  [3] = '{-7, 0, 9};
      for (int bi = 0; bi < 5; bi++) begin
        for (int oi = 0; oi < 3; oi++) begin
          int addr;
          logic [15:0] val;
          addr = (bases[bi] + offs[oi]) & 255;
          val  = vals[(bi * 3 + oi) % 8];
          clearProg();
          dmInit[addr] = val;
          prog[0] = iADDI(2, 0, bases[bi]); prog[1] = iLD(1, 2, offs[oi]);
          prog[2] = iADDI(1, 1, 1);         prog[3] = iST(1, 2, offs[oi]);
          runProg(30);
          rdMem(addr, v); check("R9 word incremented", v, val + 16'd1);
          memDiff(addr, n); check("R9 other words untouched", 16'(n), 16'h0000);
          rdReg(1, v); check("R4 loaded then incremented", v, val + 16'd1);
        end
      end
    end

    // R7: forward branch taken and not taken
    for (int t = 0; t < 2; t++) begin
      clearProg();
      prog[0] = iADDI(1, 0, 3); prog[1] = iADDI(2, 0, (t == 0) ? 3 : 4);
      prog[2] = iBEQ(1, 2, 3);
      prog[3] = iADDI(4, 0, 1); prog[4] = iADDI(5, 0, 1); prog[5] = iADDI(6, 0, 7);
      runProg(30);
      exp = (t == 0) ? 16'h0000 : 16'h0001;
      rdReg(4, v); check("R7 first younger instruction", v, exp);
      rdReg(5, v); check("R7 second younger instruction", v, exp);
      rdReg(6, v); check("R7 target instruction runs", v, 16'h0007);
      rdReg(1, v); check("R7 branch writes no register", v, 16'h0003);
      memDiff(-1, n); check("R7 branch writes no memory", 16'(n), 16'h0000);
    end

    // R7: forward and backward offsets, chained
    clearProg();
    prog[0] = iBEQ(0, 0, 4);  prog[1] = iADDI(1, 0, 1); prog[2] = iADDI(6, 0, 9);
    prog[3] = iBEQ(0, 0, 6);  prog[4] = iADDI(7, 0, 5); prog[5] = iBEQ(0, 0, -3);
    prog[6] = iADDI(2, 0, 1); prog[7] = iADDI(3, 0, 1); prog[8] = iADDI(4, 0, 1);
    runProg(30);
    rdReg(7, v); check("R7 forward target", v, 16'h0005);
    rdReg(6, v); check("R7 backward target", v, 16'h0009);
    n = 0;
    for (int r = 1; r < 6; r++) begin rdReg(r, v); if (v !== 16'h0) n++; end
    check("R7 squashed instructions leave no result", 16'(n), 16'h0000);

    // R8: load-use costs one edge
    clearProg();
    dmInit[0] = 16'd5;
    prog[0] = iLD(1, 0, 0); prog[1] = iADD(2, 1, 1);
    runProg(0);
    first = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk); rdReg(2, v);
      if (first == 0 && v == 16'd10) first = k;
    end
    check("R8 load-use result edge", 16'(first), 16'd7);

    // R8: add-to-add has no delay
    clearProg();
    prog[0] = iADDI(1, 0, 5); prog[1] = iADD(2, 1, 1);
    runProg(0);
    first = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk); rdReg(2, v);
      if (first == 0 && v == 16'd10) first = k;
    end
    check("R8 add-to-add result edge", 16'(first), 16'd6);

    // R10: same-cycle write-back read; R1: load port ignored while running
    clearProg();
    prog[0] = iADDI(3, 0, 9); prog[1] = iADDI(4, 0, 1);
    prog[2] = iADDI(5, 0, 2); prog[3] = iADD(6, 3, 3);
    runProg(20);
    progSel = 1'b1; progAddr = 8'd9; progData = 16'hDEAD; progWe = 1'b1;
    @(negedge clk);
    progWe = 1'b0;
    repeat (3) @(negedge clk);
    rdReg(6, v); check("R10 write-back bypass read", v, 16'd18);
    rdMem(9, v); check("R1 load port ignored when running", v, dmInit[9]);

    // R1: reset clears registers and fetch address
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 pc after reset", {8'h00, dbgPc}, 16'h0000);
    n = 0;
    for (int r = 0; r < 8; r++) begin rdReg(r, v); if (v !== 16'h0) n++; end
    check("R1 registers after reset", 16'(n), 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule